// File: doc/BRIEF.md
# NaN Classifier and Quieter

This unit inspects one floating-point operand and tells whether it is a NaN and, if so, whether it is the quiet or the signaling kind. In the same cycle it produces a quieted copy of the operand and the canonical default NaN for the selected format. Three formats are handled: binary16, bfloat16 and binary32, picked by a format select. The 16-bit formats sit in the low half of the operand word.

Two static controls shape the classification. A polarity input selects which value of the fraction's top bit marks a signaling NaN. A no-signaling mode treats every NaN as quiet. A two-bit style select picks one of four default NaN patterns. All results are computed combinationally and captured in one register stage. A synchronous active-high reset clears that stage.

Top module: `nan_quieter_unit`

## Requirements
- R1: `is_nan_q` is 1 exactly when the exponent field is all ones and the fraction field is nonzero, whatever the polarity or mode.
- R2: With `sig_pol` = 0, a NaN whose top fraction bit is 1 is quiet. A NaN whose top fraction bit is 0 (and has a nonzero remaining fraction) is signaling.
- R3: With `sig_pol` = 1 the meanings swap: a top fraction bit of 1 marks signaling, and a top bit of 0 with a nonzero remaining fraction marks quiet.
- R4: With `no_sig_mode` = 1, every NaN reports `is_quiet_q` = 1, and `is_sig_q` is always 0.
- R5: Infinities, zeros and ordinary numbers report `is_nan_q`, `is_quiet_q` and `is_sig_q` all 0.
- R6: For a signaling input, `quieted_q` is the operand with the top fraction bit set when `sig_pol` = 0. When `sig_pol` = 1, the top fraction bit is cleared and the next lower fraction bit is set. Sign, exponent and the other fraction bits are kept.
- R7: For any input not reported as signaling (non-NaNs, quiet NaNs, and everything in no-signaling mode), `quieted_q` equals the operand.
- R8: `dflt_nan_q` has an all-ones exponent in every style. Style 0 is sign 0 with only the top fraction bit set, or with `sig_pol` = 1 every fraction bit except the top one. Style 1 is sign 0 with all fraction bits set. Style 2 is sign 1 with only the top fraction bit set. Style 3 is sign 1 with all fraction bits set.
- R9: `fmt_sel` encodings: 0 selects binary16 (operand bits 15..0, exponent 14..10, fraction 9..0); 1 selects bfloat16 (bits 15..0, exponent 14..7, fraction 6..0); 2 and 3 both select binary32 (exponent 30..23, fraction 22..0). For the 16-bit formats, operand bits 31..16 are ignored and bits 31..16 of `quieted_q` and `dflt_nan_q` are 0.
- R10: All outputs appear on the clock edge after the inputs are presented and hold between edges. An edge with `rst` = 1 clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Format select (R9 encoding) |
| sig_pol | input | 1 | 1: top fraction bit set means signaling |
| no_sig_mode | input | 1 | 1: all NaNs treated as quiet |
| dflt_style | input | 2 | Default NaN pattern select |
| operand | input | 32 | Value under test |
| is_nan_q | output | 1 | Operand is a NaN |
| is_quiet_q | output | 1 | Operand is a quiet NaN |
| is_sig_q | output | 1 | Operand is a signaling NaN |
| quieted_q | output | 32 | Operand with a signaling NaN made quiet |
| dflt_nan_q | output | 32 | Default NaN for format, style and polarity |

## Verification
Classification and quieting always act on the same operand in the same cycle, and the quieting rule depends on the classification result. A signaling input under either polarity therefore exercises both functions at once. Each table vector sets format, polarity, mode and style together. After the register edge, the bench compares the three flags, the quieted word and the default NaN against values worked out by hand from the requirements. The polarity-1 vectors whose top fraction bit is set are the points where a wrong class would show up directly as a wrong quieted word.

// File: rtl/nanq_pkg.sv
package nanq_pkg;
  localparam int NUM_FMT = 3;
  localparam int WORD_W  = 32;

  typedef enum logic [1:0] {
    FMT_HALF       = 2'd0,
    FMT_BRAIN      = 2'd1,
    FMT_SINGLE     = 2'd2,
    FMT_SINGLE_ALT = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    STY_PLAIN     = 2'd0,
    STY_FULL      = 2'd1,
    STY_NEG_MSB   = 2'd2,
    STY_NEG_FULL  = 2'd3
  } dflt_style_e;

  // Per-lane field widths, indexed by fmt_e value
  localparam int LANE_EXP_W  [NUM_FMT] = '{5, 8, 8};
  localparam int LANE_FRAC_W [NUM_FMT] = '{10, 7, 23};

  typedef struct packed {
    logic is_nan;
    logic is_quiet;
    logic is_sig;
  } nan_class_t;
endpackage

// File: rtl/nanq_classify.sv
module nanq_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
  input  logic [TOT_W-1:0]       word,
  input  logic                   sig_pol,
  input  logic                   no_sig,
  output nanq_pkg::nan_class_t   cls
);
  logic exp_ones;
  logic top_bit;
  logic rest_nz;
  logic any_nan;
  logic top_means_sig;
  logic top_means_quiet;

  always_comb begin
    exp_ones = &word[TOT_W-2 -: EXP_W];
    top_bit  = word[FRAC_W-1];
    rest_nz  = |word[FRAC_W-2:0];
    any_nan  = exp_ones & (top_bit | rest_nz);
    // NaN with the top fraction bit set
    top_means_sig   = exp_ones & top_bit;
    // NaN with the top fraction bit clear
    top_means_quiet = exp_ones & ~top_bit & rest_nz;

    cls.is_nan = any_nan;
    if (no_sig) begin
      cls.is_quiet = any_nan;
      cls.is_sig   = 1'b0;
    end else if (sig_pol) begin
      cls.is_quiet = top_means_quiet;
      cls.is_sig   = top_means_sig;
    end else begin
      cls.is_quiet = top_means_sig;
      cls.is_sig   = top_means_quiet;
    end
  end
endmodule

// File: rtl/nanq_silence.sv
module nanq_silence #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
  input  logic [TOT_W-1:0] word,
  input  logic             is_sig,
  input  logic             sig_pol,
  output logic [TOT_W-1:0] quieted
);
  always_comb begin
    quieted = word;
    if (is_sig) begin
      if (sig_pol) begin
        quieted[FRAC_W-1] = 1'b0;
        quieted[FRAC_W-2] = 1'b1;
      end else begin
        quieted[FRAC_W-1] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nanq_dflt.sv
module nanq_dflt #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
  input  logic                  sig_pol,
  input  nanq_pkg::dflt_style_e style,
  output logic [TOT_W-1:0]      pattern
);
  localparam logic [FRAC_W-1:0] FR_TOP   = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] FR_ALL   = {FRAC_W{1'b1}};
  localparam logic [FRAC_W-1:0] FR_BELOW = {1'b0, {(FRAC_W-1){1'b1}}};
  localparam logic [EXP_W-1:0]  EX_ONES  = {EXP_W{1'b1}};

  logic              sgn;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    unique case (style)
      nanq_pkg::STY_PLAIN: begin
        sgn  = 1'b0;
        frac = sig_pol ? FR_BELOW : FR_TOP;
      end
      nanq_pkg::STY_FULL: begin
        sgn  = 1'b0;
        frac = FR_ALL;
      end
      nanq_pkg::STY_NEG_MSB: begin
        sgn  = 1'b1;
        frac = FR_TOP;
      end
      default: begin
        sgn  = 1'b1;
        frac = FR_ALL;
      end
    endcase
    pattern = {sgn, EX_ONES, frac};
  end
endmodule

// File: rtl/nanq_lane.sv
module nanq_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
  input  logic [TOT_W-1:0]      word,
  input  logic                  sig_pol,
  input  logic                  no_sig,
  input  nanq_pkg::dflt_style_e style,
  output nanq_pkg::nan_class_t  cls,
  output logic [TOT_W-1:0]      quieted,
  output logic [TOT_W-1:0]      dflt
);
  nanq_pkg::nan_class_t cls_w;

  nanq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .word    (word),
    .sig_pol (sig_pol),
    .no_sig  (no_sig),
    .cls     (cls_w)
  );

  nanq_silence #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sil (
    .word    (word),
    .is_sig  (cls_w.is_sig),
    .sig_pol (sig_pol),
    .quieted (quieted)
  );

  nanq_dflt #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dflt (
    .sig_pol (sig_pol),
    .style   (style),
    .pattern (dflt)
  );

  assign cls = cls_w;
endmodule

// File: rtl/nan_quieter_unit.sv
module nan_quieter_unit #(
  parameter int WORD_W = nanq_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt_sel,
  input  logic              sig_pol,
  input  logic              no_sig_mode,
  input  logic [1:0]        dflt_style,
  input  logic [WORD_W-1:0] operand,
  output logic              is_nan_q,
  output logic              is_quiet_q,
  output logic              is_sig_q,
  output logic [WORD_W-1:0] quieted_q,
  output logic [WORD_W-1:0] dflt_nan_q
);
  localparam int NF = nanq_pkg::NUM_FMT;

  nanq_pkg::nan_class_t  lane_cls   [NF];
  logic [WORD_W-1:0]     lane_quiet [NF];
  logic [WORD_W-1:0]     lane_dflt  [NF];
  nanq_pkg::dflt_style_e style_e;

  assign style_e = nanq_pkg::dflt_style_e'(dflt_style);

  for (genvar g = 0; g < NF; g++) begin : g_lane
    localparam int EW = nanq_pkg::LANE_EXP_W[g];
    localparam int FW = nanq_pkg::LANE_FRAC_W[g];
    localparam int TW = 1 + EW + FW;
    logic [TW-1:0] q_l;
    logic [TW-1:0] d_l;

    nanq_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
      .word    (operand[TW-1:0]),
      .sig_pol (sig_pol),
      .no_sig  (no_sig_mode),
      .style   (style_e),
      .cls     (lane_cls[g]),
      .quieted (q_l),
      .dflt    (d_l)
    );

    assign lane_quiet[g] = WORD_W'(q_l);
    assign lane_dflt[g]  = WORD_W'(d_l);
  end

  logic [1:0] lane_idx;
  always_comb begin
    lane_idx = fmt_sel;
    if (fmt_sel == nanq_pkg::FMT_SINGLE_ALT) lane_idx = nanq_pkg::FMT_SINGLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_nan_q   <= 1'b0;
      is_quiet_q <= 1'b0;
      is_sig_q   <= 1'b0;
      quieted_q  <= '0;
      dflt_nan_q <= '0;
    end else begin
      is_nan_q   <= lane_cls[lane_idx].is_nan;
      is_quiet_q <= lane_cls[lane_idx].is_quiet;
      is_sig_q   <= lane_cls[lane_idx].is_sig;
      quieted_q  <= lane_quiet[lane_idx];
      dflt_nan_q <= lane_dflt[lane_idx];
    end
  end
endmodule

// File: rtl/nanq_checker.sv
module nanq_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  fmt_sel,
  input logic        no_sig_mode,
  input logic [31:0] operand,
  input logic        is_nan_q,
  input logic        is_quiet_q,
  input logic        is_sig_q,
  input logic [31:0] quieted_q,
  input logic [31:0] dflt_nan_q
);
  logic        primed;
  logic [1:0]  fmt_d;
  logic [31:0] op_d;
  logic        nosig_d;
  logic [31:0] op_view;
  logic        dexp_ok;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
    fmt_d   <= fmt_sel;
    op_d    <= operand;
    nosig_d <= no_sig_mode;
  end

  always_comb begin
    op_view = (fmt_d < 2'd2) ? {16'h0000, op_d[15:0]} : op_d;
    case (fmt_d)
      2'd0:    dexp_ok = &dflt_nan_q[14:10];
      2'd1:    dexp_ok = &dflt_nan_q[14:7];
      default: dexp_ok = &dflt_nan_q[30:23];
    endcase
  end

  // R2 R3
  class_excl_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    !(is_quiet_q && is_sig_q));

  // R1
  nan_split_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    is_nan_q == (is_quiet_q || is_sig_q));

  // R4
  nosig_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    nosig_d |-> !is_sig_q);

  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    !is_sig_q |-> (quieted_q == op_view));

  // R8
  dflt_exp_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    dexp_ok);

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    (fmt_d < 2'd2) |-> (quieted_q[31:16] == 16'h0 && dflt_nan_q[31:16] == 16'h0));

  // R6
  sig_changes_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    is_sig_q |-> (quieted_q != op_view));
endmodule

bind nan_quieter_unit nanq_checker u_nanq_chk (
  .clk         (clk),
  .rst         (rst),
  .fmt_sel     (fmt_sel),
  .no_sig_mode (no_sig_mode),
  .operand     (operand),
  .is_nan_q    (is_nan_q),
  .is_quiet_q  (is_quiet_q),
  .is_sig_q    (is_sig_q),
  .quieted_q   (quieted_q),
  .dflt_nan_q  (dflt_nan_q)
);

// File: tb/nan_quieter_unit_bench.sv
`timescale 1ns/100ps
module nan_quieter_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_sel = 2'd2;
  logic        sig_pol = 1'b0;
  logic        no_sig_mode = 1'b0;
  logic [1:0]  dflt_style = 2'd0;
  logic [31:0] operand = 32'h0;
  logic        is_nan_q, is_quiet_q, is_sig_q;
  logic [31:0] quieted_q, dflt_nan_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  nan_quieter_unit u_nan_quieter_unit (
    .clk         (clk),
    .rst         (rst),
    .fmt_sel     (fmt_sel),
    .sig_pol     (sig_pol),
    .no_sig_mode (no_sig_mode),
    .dflt_style  (dflt_style),
    .operand     (operand),
    .is_nan_q    (is_nan_q),
    .is_quiet_q  (is_quiet_q),
    .is_sig_q    (is_sig_q),
    .quieted_q   (quieted_q),
    .dflt_nan_q  (dflt_nan_q)
  );

  // {fmt, pol, nosig, style, operand, {nan,quiet,sig}, quieted, default}
  localparam int NVEC = 15;
  localparam logic [104:0] VEC [NVEC] = '{
    // R2 quiet binary32, R8 style 0
    {2'd2,1'b0,1'b0,2'd0,32'h7FC00000,3'b110,32'h7FC00000,32'h7FC00000},
    // R2 R6 signaling binary32
    {2'd2,1'b0,1'b0,2'd0,32'h7F800001,3'b101,32'h7FC00001,32'h7FC00000},
    // R5 infinity, R8 style 1
    {2'd2,1'b0,1'b0,2'd1,32'h7F800000,3'b000,32'h7F800000,32'h7FFFFFFF},
    // R3 R6 polarity 1 signaling, R8 style 0 polarity 1
    {2'd2,1'b1,1'b0,2'd0,32'hFFC00000,3'b101,32'hFFA00000,32'h7FBFFFFF},
    // R3 R7 polarity 1 quiet, R8 style 2
    {2'd2,1'b1,1'b0,2'd2,32'h7F800001,3'b110,32'h7F800001,32'hFFC00000},
    // R4 R7 no-signaling mode, R8 style 3
    {2'd2,1'b0,1'b1,2'd3,32'h7F800001,3'b110,32'h7F800001,32'hFFFFFFFF},
    // R5 R7 ordinary number
    {2'd2,1'b0,1'b0,2'd0,32'h3F800000,3'b000,32'h3F800000,32'h7FC00000},
    // R9 binary16 signaling with junk upper half
    {2'd0,1'b0,1'b0,2'd0,32'hABCD7D00,3'b101,32'h00007F00,32'h00007E00},
    // R3 R6 binary16 polarity 1, R8 style 1
    {2'd0,1'b1,1'b0,2'd1,32'h00007E00,3'b101,32'h00007D00,32'h00007FFF},
    // R5 binary16 negative infinity, R8 style 2
    {2'd0,1'b0,1'b0,2'd2,32'h0000FC00,3'b000,32'h0000FC00,32'h0000FE00},
    // R9 bfloat16 signaling
    {2'd1,1'b0,1'b0,2'd0,32'h00007F81,3'b101,32'h00007FC1,32'h00007FC0},
    // R3 R6 R9 bfloat16 polarity 1 with junk upper half, style 3
    {2'd1,1'b1,1'b0,2'd3,32'hFFFFFFC0,3'b101,32'h0000FFA0,32'h0000FFFF},
    // R4 bfloat16 no-signaling with polarity 1
    {2'd1,1'b1,1'b1,2'd0,32'h00007FC0,3'b110,32'h00007FC0,32'h00007FBF},
    // R9 select value 3 acts as binary32
    {2'd3,1'b0,1'b0,2'd2,32'h7F800001,3'b101,32'h7FC00001,32'hFFC00000},
    // R3 R6 top-bit-only fraction under polarity 1
    {2'd2,1'b1,1'b0,2'd0,32'h7FC00000,3'b101,32'h7FA00000,32'h7FBFFFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 reset flags", {29'h0, is_nan_q, is_quiet_q, is_sig_q}, 32'h0);
    check("R10 reset quieted", quieted_q, 32'h0);
    check("R10 reset default", dflt_nan_q, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      fmt_sel     = VEC[i][104:103];
      sig_pol     = VEC[i][102];
      no_sig_mode = VEC[i][101];
      dflt_style  = VEC[i][100:99];
      operand     = VEC[i][98:67];
      @(negedge clk);
      check($sformatf("R1 R2 R3 R4 R5 flags v%0d", i),
            {29'h0, is_nan_q, is_quiet_q, is_sig_q}, {29'h0, VEC[i][66:64]});
      check($sformatf("R6 R7 R9 quieted v%0d", i), quieted_q, VEC[i][63:32]);
      check($sformatf("R8 R9 default v%0d", i), dflt_nan_q, VEC[i][31:0]);
    end

    // R10 output holds until the next edge
    fmt_sel = 2'd2; sig_pol = 1'b0; no_sig_mode = 1'b0; dflt_style = 2'd0;
    operand = 32'h7F800001;
    #1;
    check("R10 hold before edge", quieted_q, 32'h7FA00000);
    @(negedge clk);
    check("R10 update after edge", quieted_q, 32'h7FC00001);

    // R1 flag independent of mode: signaling pattern under no-signaling, polarity 1
    sig_pol = 1'b1; no_sig_mode = 1'b1; operand = 32'hFFC00000;
    @(negedge clk);
    check("R1 R4 nan flag", {31'h0, is_nan_q}, 32'h1);
    check("R4 sig forced low", {31'h0, is_sig_q}, 32'h0);

    // R5 zero under polarity 1
    no_sig_mode = 1'b0; operand = 32'h80000000;
    @(negedge clk);
    check("R5 zero flags", {29'h0, is_nan_q, is_quiet_q, is_sig_q}, 32'h0);

    // R10 reset mid-run clears outputs
    operand = 32'h7F800001; sig_pol = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid reset flags", {29'h0, is_nan_q, is_quiet_q, is_sig_q}, 32'h0);
    check("R10 mid reset quieted", quieted_q, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset", {29'h0, is_nan_q, is_quiet_q, is_sig_q}, 32'h5);

    done = 1'b1;
    finish_run();
  end
endmodule